// File: doc/BRIEF.md
# Correctable Error Address Logger

This block keeps a record of where single-bit corrected memory errors happened, so that software can locate the failing memory page after the fact. Error events come in from the memory controller's read path and from its background scrubber. Each event carries a correctable flag, a source flag (demand read or scrub read) and the page-frame bits 35:12 of the physical address. A correctable event from either source is registered in a qualification stage. It is then offered to a small capture state machine that owns two slots: a "first" slot and a "next" slot.

The state machine has four states. CAP_IDLE means both slots are empty. CAP_FIRST means only the first slot holds an address. CAP_FULL means both slots hold one. CAP_NEXT_ONLY means only the next slot holds one.

The transitions are:
- capture-to-first: CAP_IDLE to CAP_FIRST, and CAP_NEXT_ONLY to CAP_FULL.
- capture-to-next: CAP_FIRST to CAP_FULL.
- clear-first: CAP_FIRST to CAP_IDLE, and CAP_FULL to CAP_NEXT_ONLY.
- clear-next: CAP_FULL to CAP_FIRST, and CAP_NEXT_ONLY to CAP_IDLE.
- clear-both: any state to CAP_IDLE.

Events that arrive in CAP_FULL are dropped. Software reads a 32-bit word through a select input, and releases a slot by writing 1 to its bit in the status word.

The slots and the state are held only by the power-good reset. A warm reset leaves every capture in place and discards only an event that is still in the qualification stage.

Top module: `ce_addr_logger`

## Requirements
- R1: An event with `evt_valid`=1 and `evt_corr`=1 is eligible whether `evt_scrub` is 0 (demand read) or 1 (scrub read). An event with `evt_corr`=0 never changes any slot.
- R2: An address word holds page bits 35:12 in word bits 25:2. Word bits 31:26 and 1:0 always read 0.
- R3: An eligible event presented on clock edge N, with the first slot empty and no clear pending, is captured into the first slot on edge N+1. The capture is readable with `rd_sel`=0 after that edge.
- R4: An eligible event arriving while the first slot is valid and the next slot is empty is captured into the next slot (`rd_sel`=1). An event arriving while both slots are valid changes neither slot.
- R5: The status word (`rd_sel`=2) has the following bits: bit 0 is next-valid, bit 1 is first-valid, bit 2 is set when the first slot was a scrub read, and bit 3 is set when the next slot was a scrub read. All other bits read 0. An address word of an invalid slot reads 0.
- R6: A write (`sw_clr_wr`=1) clears the first slot when `sw_clr_data` bit 1 is 1 and clears the next slot when bit 0 is 1. A data bit of 0 leaves its slot unchanged.
- R7: When a clear write and a staged eligible event meet on the same edge, the clear is applied and the event is discarded. The following eligible event is captured normally.
- R8: Asserting `warm_rst_n` low leaves both slots and the status word unchanged. An event staged at the time is discarded.
- R9: Asserting `pwrgood_rst_n` low returns the state, both slots and all read words to zero.
- R10: With `rd_sel`=3 the read word is all zeros.
- R11: In CAP_NEXT_ONLY, an eligible event loads the first slot and the next slot is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrgood_rst_n | input | 1 | Asynchronous power-good reset, active low; clears all captures |
| warm_rst_n | input | 1 | Synchronous warm reset, active low; flushes the qualification stage only |
| evt_valid | input | 1 | An error event is present |
| evt_corr | input | 1 | 1 = single-bit corrected error, 0 = other error kind |
| evt_scrub | input | 1 | 1 = scrub read, 0 = demand read |
| evt_page | input | 24 | Physical address bits 35:12 of the event |
| sw_clr_wr | input | 1 | Software write strobe to the status word |
| sw_clr_data | input | 2 | Write-1-to-clear: bit 1 first slot, bit 0 next slot |
| rd_sel | input | 2 | 0 first address, 1 next address, 2 status, 3 zero |
| rd_data | output | 32 | Selected read word |

## Verification
Two pairs of functions can land on the same edge. The first pair is a software clear and the capture of a staged event. The bench provokes this by presenting an event and raising the clear strobe one cycle later, so that both reach the state machine together. It judges the outcome by reading that the slot stays empty, and then that the very next event does land in the first slot. The second pair is a warm reset and a staged event. The bench lowers the warm reset exactly while an event sits in the stage, and requires that both slots and the status word are unchanged afterwards.

// File: rtl/ce_log_pkg.sv
package ce_log_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE      = 2'd0,
        CAP_FIRST     = 2'd1,
        CAP_FULL      = 2'd2,
        CAP_NEXT_ONLY = 2'd3
    } cap_state_e;

    localparam int NUM_SLOTS  = 2;
    localparam int SLOT_FIRST = 0;
    localparam int SLOT_NEXT  = 1;

    // status word bit positions
    localparam int ST_NEXT_VLD  = 0;
    localparam int ST_FIRST_VLD = 1;
    localparam int ST_FIRST_SCR = 2;
    localparam int ST_NEXT_SCR  = 3;

    // read selector codes
    localparam logic [1:0] SEL_FIRST  = 2'd0;
    localparam logic [1:0] SEL_NEXT   = 2'd1;
    localparam logic [1:0] SEL_STATUS = 2'd2;

endpackage

// File: rtl/ce_evt_stage.sv
module ce_evt_stage #(
    parameter int FIELD_W = 24
) (
    input  logic               clk,
    input  logic               pg_rst_n,
    input  logic               warm_rst_n,
    input  logic               evt_valid,
    input  logic               evt_corr,
    input  logic               evt_scrub,
    input  logic [FIELD_W-1:0] evt_page,
    output logic               stg_valid,
    output logic               stg_scrub,
    output logic [FIELD_W-1:0] stg_page
);

    logic eligible;

    // demand reads and scrub reads are both eligible; only corrected ones
    assign eligible = evt_valid && evt_corr;

    always_ff @(posedge clk or negedge pg_rst_n) begin
        if (!pg_rst_n) begin
            stg_valid <= 1'b0;
            stg_scrub <= 1'b0;
            stg_page  <= '0;
        end else if (!warm_rst_n) begin
            stg_valid <= 1'b0;
            stg_scrub <= 1'b0;
            stg_page  <= '0;
        end else begin
            stg_valid <= eligible;
            if (eligible) begin
                stg_scrub <= evt_scrub;
                stg_page  <= evt_page;
            end
        end
    end

endmodule

// File: rtl/ce_capture_fsm.sv
module ce_capture_fsm
    import ce_log_pkg::*;
(
    input  logic       clk,
    input  logic       pg_rst_n,
    input  logic       warm_rst_n,
    input  logic       stg_valid,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    output cap_state_e state,
    output logic       first_vld,
    output logic       next_vld,
    output logic       ld_first,
    output logic       ld_next
);

    cap_state_e state_nx;
    logic       clr_first;
    logic       clr_next;
    logic       clr_any;
    logic       accept;

    assign clr_first = clr_wr && clr_bits[ST_FIRST_VLD];
    assign clr_next  = clr_wr && clr_bits[ST_NEXT_VLD];
    assign clr_any   = clr_first || clr_next;
    // a clear on the same edge wins; a warm reset flushes the staged event
    assign accept    = stg_valid && warm_rst_n && !clr_any;

    // state register: held only by power-good reset
    always_ff @(posedge clk or negedge pg_rst_n) begin
        if (!pg_rst_n) begin
            state <= CAP_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CAP_IDLE: begin
                if (accept) begin
                    state_nx = CAP_FIRST;
                end
            end
            CAP_FIRST: begin
                if (clr_first) begin
                    state_nx = CAP_IDLE;
                end else if (accept) begin
                    state_nx = CAP_FULL;
                end
            end
            CAP_FULL: begin
                if (clr_first && clr_next) begin
                    state_nx = CAP_IDLE;
                end else if (clr_first) begin
                    state_nx = CAP_NEXT_ONLY;
                end else if (clr_next) begin
                    state_nx = CAP_FIRST;
                end
            end
            CAP_NEXT_ONLY: begin
                if (clr_next) begin
                    state_nx = CAP_IDLE;
                end else if (accept) begin
                    state_nx = CAP_FULL;
                end
            end
            default: state_nx = CAP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        first_vld = 1'b0;
        next_vld  = 1'b0;
        ld_first  = 1'b0;
        ld_next   = 1'b0;
        unique case (state)
            CAP_IDLE: begin
                ld_first = accept;
            end
            CAP_FIRST: begin
                first_vld = 1'b1;
                ld_next   = accept;
            end
            CAP_FULL: begin
                first_vld = 1'b1;
                next_vld  = 1'b1;
            end
            CAP_NEXT_ONLY: begin
                next_vld = 1'b1;
                ld_first = accept;
            end
            default: begin
                first_vld = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ce_addr_slot.sv
module ce_addr_slot #(
    parameter int FIELD_W = 24
) (
    input  logic               clk,
    input  logic               pg_rst_n,
    input  logic               ld,
    input  logic [FIELD_W-1:0] d_page,
    input  logic               d_scrub,
    output logic [FIELD_W-1:0] q_page,
    output logic               q_scrub
);

    always_ff @(posedge clk or negedge pg_rst_n) begin
        if (!pg_rst_n) begin
            q_page  <= '0;
            q_scrub <= 1'b0;
        end else if (ld) begin
            q_page  <= d_page;
            q_scrub <= d_scrub;
        end
    end

endmodule

// File: rtl/ce_rd_mux.sv
module ce_rd_mux
    import ce_log_pkg::*;
#(
    parameter int FIELD_W   = 24,
    parameter int FIELD_LSB = 2,
    parameter int WORD_W    = 32
) (
    input  logic [1:0]         rd_sel,
    input  logic               first_vld,
    input  logic               next_vld,
    input  logic [FIELD_W-1:0] first_page,
    input  logic [FIELD_W-1:0] next_page,
    input  logic               first_scrub,
    input  logic               next_scrub,
    output logic [WORD_W-1:0]  rd_data
);

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_FIRST: begin
                if (first_vld) begin
                    rd_data[FIELD_LSB +: FIELD_W] = first_page;
                end
            end
            SEL_NEXT: begin
                if (next_vld) begin
                    rd_data[FIELD_LSB +: FIELD_W] = next_page;
                end
            end
            SEL_STATUS: begin
                rd_data[ST_NEXT_VLD]  = next_vld;
                rd_data[ST_FIRST_VLD] = first_vld;
                rd_data[ST_FIRST_SCR] = first_vld && first_scrub;
                rd_data[ST_NEXT_SCR]  = next_vld && next_scrub;
            end
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ce_addr_logger.sv
module ce_addr_logger
    import ce_log_pkg::*;
#(
    parameter int PADDR_W   = 36,
    parameter int PAGE_LSB  = 12,
    parameter int WORD_W    = 32,
    parameter int FIELD_LSB = 2,
    parameter int FIELD_W   = PADDR_W - PAGE_LSB
) (
    input  logic               clk,
    input  logic               pwrgood_rst_n,
    input  logic               warm_rst_n,
    input  logic               evt_valid,
    input  logic               evt_corr,
    input  logic               evt_scrub,
    input  logic [FIELD_W-1:0] evt_page,
    input  logic               sw_clr_wr,
    input  logic [1:0]         sw_clr_data,
    input  logic [1:0]         rd_sel,
    output logic [WORD_W-1:0]  rd_data
);

    logic               stg_valid;
    logic               stg_scrub;
    logic [FIELD_W-1:0] stg_page;
    cap_state_e         cap_state;
    logic               first_vld;
    logic               next_vld;
    logic [NUM_SLOTS-1:0] ld_vec;
    logic [FIELD_W-1:0] slot_page [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] slot_scrub;

    ce_evt_stage #(.FIELD_W(FIELD_W)) u_stage (
        .clk        (clk),
        .pg_rst_n   (pwrgood_rst_n),
        .warm_rst_n (warm_rst_n),
        .evt_valid  (evt_valid),
        .evt_corr   (evt_corr),
        .evt_scrub  (evt_scrub),
        .evt_page   (evt_page),
        .stg_valid  (stg_valid),
        .stg_scrub  (stg_scrub),
        .stg_page   (stg_page)
    );

    ce_capture_fsm u_fsm (
        .clk        (clk),
        .pg_rst_n   (pwrgood_rst_n),
        .warm_rst_n (warm_rst_n),
        .stg_valid  (stg_valid),
        .clr_wr     (sw_clr_wr),
        .clr_bits   (sw_clr_data),
        .state      (cap_state),
        .first_vld  (first_vld),
        .next_vld   (next_vld),
        .ld_first   (ld_vec[SLOT_FIRST]),
        .ld_next    (ld_vec[SLOT_NEXT])
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        ce_addr_slot #(.FIELD_W(FIELD_W)) u_slot (
            .clk      (clk),
            .pg_rst_n (pwrgood_rst_n),
            .ld       (ld_vec[g]),
            .d_page   (stg_page),
            .d_scrub  (stg_scrub),
            .q_page   (slot_page[g]),
            .q_scrub  (slot_scrub[g])
        );
    end

    ce_rd_mux #(
        .FIELD_W   (FIELD_W),
        .FIELD_LSB (FIELD_LSB),
        .WORD_W    (WORD_W)
    ) u_mux (
        .rd_sel      (rd_sel),
        .first_vld   (first_vld),
        .next_vld    (next_vld),
        .first_page  (slot_page[SLOT_FIRST]),
        .next_page   (slot_page[SLOT_NEXT]),
        .first_scrub (slot_scrub[SLOT_FIRST]),
        .next_scrub  (slot_scrub[SLOT_NEXT]),
        .rd_data     (rd_data)
    );

endmodule

// File: rtl/ce_addr_logger_chk.sv
module ce_addr_logger_chk
    import ce_log_pkg::*;
#(
    parameter int FIELD_W   = 24,
    parameter int FIELD_LSB = 2,
    parameter int WORD_W    = 32
) (
    input logic               clk,
    input logic               pwrgood_rst_n,
    input logic               warm_rst_n,
    input logic               evt_valid,
    input logic               evt_corr,
    input logic               sw_clr_wr,
    input logic [1:0]         sw_clr_data,
    input logic [1:0]         rd_sel,
    input logic [WORD_W-1:0]  rd_data,
    input logic               stg_valid,
    input cap_state_e         cap_state,
    input logic               first_vld,
    input logic               next_vld,
    input logic [FIELD_W-1:0] first_page,
    input logic [FIELD_W-1:0] next_page
);

    localparam int FIELD_TOP = FIELD_LSB + FIELD_W;

    logic clr_any;
    assign clr_any = sw_clr_wr && (|sw_clr_data);

    // R1: an uncorrected event never reaches the stage
    assert_uncorr_dropped_R1: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (evt_valid && !evt_corr) |=> !stg_valid);

    // R2: reserved bits of address words read zero
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (rd_sel != SEL_STATUS) |-> (rd_data[WORD_W-1:FIELD_TOP] == '0 && rd_data[FIELD_LSB-1:0] == '0));

    // R3: staged event in empty machine lands in the first slot
    assert_first_capture_R3: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (cap_state == CAP_IDLE && stg_valid && warm_rst_n && !clr_any) |=> (first_vld && !next_vld));

    // R4: both slots full and no clear means nothing moves
    assert_no_overwrite_R4: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (cap_state == CAP_FULL && !clr_any) |=> ($stable(first_page) && $stable(next_page) && first_vld && next_vld));

    // R5: status word upper bits zero
    assert_status_clean_R5: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (rd_sel == SEL_STATUS) |-> (rd_data[WORD_W-1:4] == '0));

    // R6/R7: clearing the first slot wins over a same-edge capture
    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (sw_clr_wr && sw_clr_data[ST_FIRST_VLD]) |=> !first_vld);

    // R6: clearing next slot always empties it
    assert_clear_next_R6: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (sw_clr_wr && sw_clr_data[ST_NEXT_VLD]) |=> !next_vld);

    // R8: warm reset without a clear leaves the captures alone
    assert_warm_keeps_R8: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (!warm_rst_n && !clr_any) |=> ($stable(cap_state) && $stable(first_page) && $stable(next_page)));

    // R10: unused selector reads zero
    assert_sel3_zero_R10: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (rd_sel == 2'd3) |-> (rd_data == '0));

    // R11: event in next-only state fills first and keeps next
    assert_next_only_fill_R11: assert property (@(posedge clk) disable iff (!pwrgood_rst_n)
        (cap_state == CAP_NEXT_ONLY && stg_valid && warm_rst_n && !clr_any) |=> (first_vld && next_vld && $stable(next_page)));

endmodule

bind ce_addr_logger ce_addr_logger_chk #(
    .FIELD_W   (FIELD_W),
    .FIELD_LSB (FIELD_LSB),
    .WORD_W    (WORD_W)
) u_chk (
    .clk           (clk),
    .pwrgood_rst_n (pwrgood_rst_n),
    .warm_rst_n    (warm_rst_n),
    .evt_valid     (evt_valid),
    .evt_corr      (evt_corr),
    .sw_clr_wr     (sw_clr_wr),
    .sw_clr_data   (sw_clr_data),
    .rd_sel        (rd_sel),
    .rd_data       (rd_data),
    .stg_valid     (stg_valid),
    .cap_state     (cap_state),
    .first_vld     (first_vld),
    .next_vld      (next_vld),
    .first_page    (slot_page[0]),
    .next_page     (slot_page[1])
);

// File: tb/ce_addr_logger_test.sv
`timescale 1ns/1ps
module ce_addr_logger_test;

    localparam int FW = 24;

    logic          clk = 1'b0;
    logic          pwrgood_rst_n = 1'b0;
    logic          warm_rst_n = 1'b1;
    logic          evt_valid = 1'b0;
    logic          evt_corr = 1'b0;
    logic          evt_scrub = 1'b0;
    logic [FW-1:0] evt_page = '0;
    logic          sw_clr_wr = 1'b0;
    logic [1:0]    sw_clr_data = 2'b00;
    logic [1:0]    rd_sel = 2'd0;
    logic [31:0]   rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    ce_addr_logger uut (
        .clk           (clk),
        .pwrgood_rst_n (pwrgood_rst_n),
        .warm_rst_n    (warm_rst_n),
        .evt_valid     (evt_valid),
        .evt_corr      (evt_corr),
        .evt_scrub     (evt_scrub),
        .evt_page      (evt_page),
        .sw_clr_wr     (sw_clr_wr),
        .sw_clr_data   (sw_clr_data),
        .rd_sel        (rd_sel),
        .rd_data       (rd_data)
    );

    // R2 word layout: page bits in 25:2
    function automatic logic [31:0] addr_word(input logic [FW-1:0] p);
        return {6'b0, p, 2'b00};
    endfunction

    // monitor: pops one expectation per cycle and compares
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    // driver: select a word and push its expected value
    task automatic expect_rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        exp_item_t it;
        @(negedge clk);
        rd_sel = sel;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic send_evt(input logic corr, input logic scrub, input logic [FW-1:0] page);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_corr  = corr;
        evt_scrub = scrub;
        evt_page  = page;
        @(negedge clk);
        evt_valid = 1'b0;
        evt_corr  = 1'b0;
        @(negedge clk);
    endtask

    task automatic sw_clear(input logic [1:0] bits);
        @(negedge clk);
        sw_clr_wr   = 1'b1;
        sw_clr_data = bits;
        @(negedge clk);
        sw_clr_wr   = 1'b0;
        sw_clr_data = 2'b00;
    endtask

    localparam logic [FW-1:0] PA = 24'hABCDE1;
    localparam logic [FW-1:0] PB = 24'h123456;
    localparam logic [FW-1:0] PC = 24'h0FFFFF;
    localparam logic [FW-1:0] PD = 24'h777777;
    localparam logic [FW-1:0] PE = 24'h5A5A5A;
    localparam logic [FW-1:0] PF = 24'hFFFFFF;
    localparam logic [FW-1:0] PG = 24'h000001;
    localparam logic [FW-1:0] PH = 24'hC0FFEE;

    initial begin
        repeat (3) @(negedge clk);
        pwrgood_rst_n = 1'b1;

        // reset state
        expect_rd(2'd0, 32'h0, "R9 first word after power-good");
        expect_rd(2'd1, 32'h0, "R9 next word after power-good");
        expect_rd(2'd2, 32'h0, "R9 status after power-good");

        // uncorrected event ignored
        send_evt(1'b0, 1'b0, PD);
        expect_rd(2'd2, 32'h0, "R1 uncorrected event ignored");
        expect_rd(2'd0, 32'h0, "R1 first word untouched");

        // demand read into first slot
        send_evt(1'b1, 1'b0, PA);
        expect_rd(2'd0, addr_word(PA), "R3 first capture R2 layout");
        expect_rd(2'd2, 32'h2, "R5 status first valid");
        expect_rd(2'd1, 32'h0, "R5 invalid next word reads 0");

        // scrub read into next slot
        send_evt(1'b1, 1'b1, PB);
        expect_rd(2'd1, addr_word(PB), "R4 next capture");
        expect_rd(2'd2, 32'hB, "R1 R5 status with scrub next");

        // both full: further event dropped
        send_evt(1'b1, 1'b0, PC);
        expect_rd(2'd0, addr_word(PA), "R4 first not overwritten");
        expect_rd(2'd1, addr_word(PB), "R4 next not overwritten");

        // warm reset while an event is staged (slot full, so clear next first)
        sw_clear(2'b01);
        @(negedge clk);
        evt_valid = 1'b1; evt_corr = 1'b1; evt_scrub = 1'b0; evt_page = PD;
        @(negedge clk);
        evt_valid = 1'b0; evt_corr = 1'b0; warm_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        warm_rst_n = 1'b1;
        expect_rd(2'd2, 32'h2, "R8 warm reset keeps status, drops staged");
        expect_rd(2'd0, addr_word(PA), "R8 warm reset keeps first");

        // writing zeros has no effect
        send_evt(1'b1, 1'b1, PB);
        sw_clear(2'b00);
        expect_rd(2'd2, 32'hB, "R6 zero write no effect");

        // clear next only
        sw_clear(2'b01);
        expect_rd(2'd2, 32'h2, "R6 clear next");
        expect_rd(2'd1, 32'h0, "R6 cleared next word reads 0");

        // conflict: clear first on the capture edge
        @(negedge clk);
        evt_valid = 1'b1; evt_corr = 1'b1; evt_scrub = 1'b0; evt_page = PE;
        @(negedge clk);
        evt_valid = 1'b0; evt_corr = 1'b0;
        sw_clr_wr = 1'b1; sw_clr_data = 2'b10;
        @(negedge clk);
        sw_clr_wr = 1'b0; sw_clr_data = 2'b00;
        expect_rd(2'd2, 32'h0, "R7 clear wins over same-edge event");
        expect_rd(2'd0, 32'h0, "R7 event not captured");

        send_evt(1'b1, 1'b0, PF);
        expect_rd(2'd0, addr_word(PF), "R7 following event captured");

        // next-only state fill
        send_evt(1'b1, 1'b1, PG);
        sw_clear(2'b10);
        expect_rd(2'd2, 32'h9, "R6 clear first leaves next");
        send_evt(1'b1, 1'b0, PH);
        expect_rd(2'd0, addr_word(PH), "R11 first filled from next-only");
        expect_rd(2'd1, addr_word(PG), "R11 next kept");
        expect_rd(2'd2, 32'hB, "R11 status both valid");
        expect_rd(2'd3, 32'h0, "R10 unused select reads zero");

        // power-good reset clears everything
        @(negedge clk);
        pwrgood_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        pwrgood_rst_n = 1'b1;
        expect_rd(2'd2, 32'h0, "R9 status cleared by power-good");
        expect_rd(2'd0, 32'h0, "R9 first cleared by power-good");
        expect_rd(2'd1, 32'h0, "R9 next cleared by power-good");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule